// File: doc/BRIEF.md
# Instruction skip mask sequencer

This block sits next to the issue stage of a small processor and decides, for each issued instruction, whether that instruction is cancelled. A skip command carries a 32-bit mask. The block copies the mask into a private shift register. Each later instruction that issues while the sequence is live takes the lowest bit, and a set bit turns that instruction into a no-operation. The issue stage still spends the normal slot on a cancelled instruction and treats it as if its condition test had failed. A pending operand prefix is used up by it. Prefix words are separate issues, so each one takes its own bit.

Skipping pauses inside called routines and interrupt handlers. A call that is not cancelled takes one bit for itself, and a call-depth counter then holds the mask still until the matching return. Calls can nest, and the counter saturates at eight levels. Interrupt entry and exit set and clear a separate handler flag that also pauses the mask. Jumps get no special treatment: the remaining bits go to whatever issues next. A new skip command replaces whatever sequence exists, whether it is running or paused. An all-zero mask ends skipping.

Top module: `skip_seq_top`

## Requirements
- R1: After reset, and whenever the mask register is zero, `cancel_o` stays low on every issue.
- R2: A skip command (issue with `load_i`) copies `mask_i` into the shift register. Bit 0 decides cancellation of the first later live issue and bit 31 decides the 32nd. Issues between them, jumps included, take bits 1..30 in order. After 32 live issues, no later issue is cancelled.
- R3: `mask_i` is sampled only by an accepted skip command. Its value on any other cycle has no effect.
- R4: On a live issue whose current bit is 1, `cancel_o` is high in the same cycle. The bit is consumed, and any call, return or skip command carried by that issue has no effect.
- R5: A live call that is not cancelled consumes one bit and raises the call depth. While the depth is nonzero, no issue is cancelled and no bit is consumed. A return at nonzero depth lowers the depth, and consumption resumes when the depth reaches zero.
- R6: The call depth saturates at 8. A call issued at depth 8 leaves it at 8, so eight returns resume the sequence.
- R7: `irq_enter_i` pauses the mask and `irq_exit_i` resumes it. While inside the handler, a skip command is ignored.
- R8: A return issued at depth zero outside a handler is never cancelled and consumes no bit.
- R9: An accepted skip command discards the current sequence and clears the call depth, even when the old sequence is paused inside a call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | One instruction issues this cycle |
| load_i | input | 1 | The issuing instruction is a skip command |
| mask_i | input | 32 | Mask operand of the skip command |
| call_i | input | 1 | The issuing instruction is a subroutine call |
| ret_i | input | 1 | The issuing instruction is a subroutine return |
| irq_enter_i | input | 1 | Interrupt handler entered (between issues) |
| irq_exit_i | input | 1 | Interrupt handler returned (between issues) |
| cancel_o | output | 1 | The issuing instruction is cancelled |

## Verification
The bench aims at the cycles where a call or return issues. A design that consumed a bit on the call's own cycle twice, or let a return at depth zero take a bit, would be one position off for the rest of the mask. A cancelled call tests whether the depth counter wrongly advances, which would freeze the sequence for good. Nine nested calls followed by eight returns expose a counter that does not saturate: such a design stays paused. Skip commands issued while paused in a call and while inside a handler check that the first discards the old sequence and the second is dropped. A mask with bit 31 set checks that the last bit lands on exactly the 32nd issue.

// File: rtl/skip_seq_pkg.sv
package skip_seq_pkg;

  typedef struct packed {
    logic live;
    logic cancel;
    logic shift;
    logic load;
    logic call;
    logic ret;
  } skip_ctl_t;

endpackage

// File: rtl/skip_mask_shreg.sv
module skip_mask_shreg #(
  parameter int MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [MASK_W-1:0] load_val,
  input  logic              shift_en,
  output logic [MASK_W-1:0] mask_q
);

  logic [MASK_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (load_en) begin
      mask_d = load_val;
    end else if (shift_en) begin
      mask_d = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (load_en || shift_en) begin
      mask_q <= mask_d;
    end
  end

  a_r2_shift_one: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> (mask_q == ($past(mask_q) >> 1)));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !shift_en) |=> $stable(mask_q));

endmodule

// File: rtl/skip_nest_ctr.sv
module skip_nest_ctr #(
  parameter int MAX_NEST = 8,
  localparam int DEPTH_W = $clog2(MAX_NEST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               call_en,
  input  logic               ret_en,
  input  logic               clear_en,
  input  logic               irq_enter,
  input  logic               irq_exit,
  output logic [DEPTH_W-1:0] depth_q,
  output logic               in_isr_q
);

  localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(MAX_NEST);

  logic [DEPTH_W-1:0] depth_d;
  logic               isr_d;
  logic               depth_ce;

  always_comb begin
    depth_d = depth_q;
    if (clear_en) begin
      depth_d = '0;
    end else if (call_en && (depth_q != DEPTH_MAX)) begin
      depth_d = depth_q + 1'b1;
    end else if (ret_en && (depth_q != '0)) begin
      depth_d = depth_q - 1'b1;
    end
    depth_ce = clear_en || call_en || ret_en;
  end

  always_comb begin
    isr_d = in_isr_q;
    if (irq_enter) begin
      isr_d = 1'b1;
    end else if (irq_exit) begin
      isr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else if (depth_ce) begin
      depth_q <= depth_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_isr_q <= 1'b0;
    end else if (irq_enter || irq_exit) begin
      in_isr_q <= isr_d;
    end
  end

  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEPTH_MAX);

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (call_en && !clear_en && depth_q == DEPTH_MAX) |=> (depth_q == DEPTH_MAX));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |=> (depth_q == '0));

endmodule

// File: rtl/skip_issue_ctl.sv
module skip_issue_ctl
  import skip_seq_pkg::*;
(
  input  logic      issue,
  input  logic      load_req,
  input  logic      call_req,
  input  logic      ret_req,
  input  logic      mask_lsb,
  input  logic      depth_zero,
  input  logic      in_isr,
  output skip_ctl_t ctl
);

  logic paused;
  logic ret_flat;

  always_comb begin
    paused     = !depth_zero || in_isr;
    ret_flat   = ret_req && depth_zero;
    ctl.live   = issue && !paused;
    ctl.cancel = ctl.live && mask_lsb && !ret_flat;
    ctl.load   = issue && load_req && !in_isr && !ctl.cancel;
    ctl.shift  = ctl.live && !ret_flat && !ctl.load;
    ctl.call   = issue && call_req && !ctl.cancel && !ctl.load;
    ctl.ret    = issue && ret_req && !depth_zero;
  end

  always_comb begin
    if (ctl.cancel) begin
      a_r4_cancel_live: assert (issue && !paused);
    end
  end

endmodule

// File: rtl/skip_seq_top.sv
module skip_seq_top
  import skip_seq_pkg::*;
#(
  parameter int MASK_W   = 32,
  parameter int MAX_NEST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              load_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              irq_enter_i,
  input  logic              irq_exit_i,
  output logic              cancel_o
);

  localparam int DEPTH_W = $clog2(MAX_NEST + 1);

  logic [MASK_W-1:0]  mask_q;
  logic [DEPTH_W-1:0] depth_q;
  logic               in_isr_q;
  skip_ctl_t          ctl;

  skip_issue_ctl u_ctl (
    .issue      (issue_i),
    .load_req   (load_i),
    .call_req   (call_i),
    .ret_req    (ret_i),
    .mask_lsb   (mask_q[0]),
    .depth_zero (depth_q == '0),
    .in_isr     (in_isr_q),
    .ctl        (ctl)
  );

  skip_mask_shreg #(.MASK_W(MASK_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (ctl.load),
    .load_val (mask_i),
    .shift_en (ctl.shift),
    .mask_q   (mask_q)
  );

  skip_nest_ctr #(.MAX_NEST(MAX_NEST)) u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_en   (ctl.call),
    .ret_en    (ctl.ret),
    .clear_en  (ctl.load),
    .irq_enter (irq_enter_i),
    .irq_exit  (irq_exit_i),
    .depth_q   (depth_q),
    .in_isr_q  (in_isr_q)
  );

  assign cancel_o = ctl.cancel;

  a_r5_no_cancel_paused: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (depth_q != '0)) |-> !cancel_o);

  a_r7_isr_load_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && load_i && in_isr_q) |=> $stable(mask_q));

  a_r1_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !cancel_o);

  a_r4_cancel_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |-> issue_i);

endmodule

// File: tb/skip_seq_top_test.sv
`timescale 1ns/1ps
module skip_seq_top_test;

  logic        clk;
  logic        rst_n;
  logic        issue_i, load_i, call_i, ret_i, irq_enter_i, irq_exit_i;
  logic [31:0] mask_i;
  logic        cancel_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bit    q_exp[$];
  string q_tag[$];

  // reference model state
  logic [31:0] m_mask;
  int          m_depth;
  bit          m_isr;

  skip_seq_top uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .load_i(load_i),
    .mask_i(mask_i), .call_i(call_i), .ret_i(ret_i),
    .irq_enter_i(irq_enter_i), .irq_exit_i(irq_exit_i), .cancel_o(cancel_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic clear_inputs();
    issue_i = 0; load_i = 0; call_i = 0; ret_i = 0;
    irq_enter_i = 0; irq_exit_i = 0;
    mask_i = 32'hFFFF_FFFF; // R3: garbage operand on non-load cycles
  endtask

  task automatic issue(input bit c, input bit r, input bit l,
                       input logic [31:0] m, input string tag);
    bit paused, flat, live, exp;
    @(posedge clk); #1;
    clear_inputs();
    issue_i = 1; call_i = c; ret_i = r; load_i = l;
    if (l) mask_i = m;
    paused = (m_depth != 0) || m_isr;
    flat   = r && (m_depth == 0);
    live   = !paused;
    exp    = live && m_mask[0] && !flat;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    if (exp) begin
      m_mask = m_mask >> 1;
    end else if (l && !m_isr) begin
      m_mask = m; m_depth = 0;
    end else begin
      if (live && !flat) m_mask = m_mask >> 1;
      if (c && m_depth < 8) m_depth++;
      else if (r && m_depth > 0) m_depth--;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      clear_inputs();
    end
  endtask

  task automatic irq(input bit enter);
    @(posedge clk); #1;
    clear_inputs();
    if (enter) irq_enter_i = 1; else irq_exit_i = 1;
    m_isr = enter;
  endtask

  // monitor: compare each issue against the scoreboard
  always @(negedge clk) begin
    if (rst_n && issue_i) begin
      n_checks++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: actual cancel=%0b expected none", cancel_o);
      end else begin
        bit e; string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (cancel_o !== e) begin
          n_fail++;
          $display("FAIL %s: cancel actual=%0b expected=%0b", t, cancel_o, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    m_mask = '0; m_depth = 0; m_isr = 0;
    rst_n = 0;
    #12 rst_n = 1;

    // R1: reset state, issues with no sequence
    @(negedge clk);
    n_checks++;
    if (cancel_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: reset cancel actual=%0b expected=0", cancel_o);
    end
    for (int i = 0; i < 3; i++) issue(0, 0, 0, '0, "R1");

    // R2/R3: bit ordering across 32 issues, then quiet
    issue(0, 0, 1, 32'h8000_00A5, "R2");
    for (int i = 0; i < 34; i++) issue(0, 0, 0, '0, "R2");

    // R5: call consumes one bit, pauses, resumes after return
    issue(0, 0, 1, 32'b1101_1010, "R5");
    issue(0, 0, 0, '0, "R5");      // bit0=0
    issue(1, 0, 0, '0, "R5");      // call, bit1=1 -> cancelled (R4)
    issue(1, 0, 0, '0, "R5");      // call, bit2=0 -> taken
    issue(0, 0, 0, '0, "R5");      // inside, paused
    issue(0, 0, 0, '0, "R5");
    issue(0, 1, 0, '0, "R5");      // return
    for (int i = 0; i < 5; i++) issue(0, 0, 0, '0, "R5");

    // R4: cancelled skip command leaves the old sequence running
    issue(0, 0, 1, 32'b0101, "R4");
    issue(0, 0, 1, 32'hFFFF_FFFF, "R4");   // cancelled load
    issue(0, 0, 0, '0, "R4");
    issue(0, 0, 0, '0, "R4");
    issue(0, 0, 0, '0, "R4");

    // R6: nine calls, eight returns resume
    issue(0, 0, 1, 32'b1010, "R6");
    issue(1, 0, 0, '0, "R6");
    for (int i = 0; i < 8; i++) issue(1, 0, 0, '0, "R6");
    issue(0, 0, 0, '0, "R6");
    for (int i = 0; i < 8; i++) issue(0, 1, 0, '0, "R6");
    for (int i = 0; i < 3; i++) issue(0, 0, 0, '0, "R6");

    // R7: interrupt pauses; skip command inside handler dropped
    issue(0, 0, 1, 32'b1101, "R7");
    issue(0, 0, 0, '0, "R7");
    irq(1);
    issue(0, 0, 0, '0, "R7");
    issue(0, 0, 1, 32'h0000_0000, "R7");
    issue(0, 0, 0, '0, "R7");
    irq(0);
    for (int i = 0; i < 4; i++) issue(0, 0, 0, '0, "R7");

    // R8: return at depth zero neither cancels nor consumes
    issue(0, 0, 1, 32'b0111, "R8");
    issue(0, 1, 0, '0, "R8");
    issue(0, 1, 0, '0, "R8");
    for (int i = 0; i < 4; i++) issue(0, 0, 0, '0, "R8");

    // R9: new skip command inside a call discards and clears depth
    issue(0, 0, 1, 32'b0000_0010, "R9");
    issue(1, 0, 0, '0, "R9");
    issue(1, 0, 0, '0, "R9");
    issue(0, 0, 1, 32'b0011, "R9");
    issue(0, 0, 0, '0, "R9");
    issue(0, 0, 0, '0, "R9");
    issue(0, 1, 0, '0, "R9");
    issue(0, 0, 0, '0, "R9");

    // R1: zero mask ends skipping early
    issue(0, 0, 1, 32'hFFFF_FFFF, "R1");
    issue(0, 0, 0, '0, "R1");
    issue(0, 0, 1, 32'h0, "R1");
    for (int i = 0; i < 4; i++) issue(0, 0, 0, '0, "R1");

    idle(3);
    if (q_exp.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: actual leftover=%0d expected=0", q_exp.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule